// File: doc/BRIEF.md
# Multi-bank DRAM request scheduler

This block sits in front of one DRAM channel and decides the order in which read and write requests reach the shared address bus. Each incoming request carries a byte address, a write flag and a tag. The block decodes the DIMM, rank and bank from fixed address bits and places the request in the queue for that bank. There are 32 queues: 2 DIMMs, 2 ranks per DIMM and 8 banks per rank. While the target queue is full, the request port deasserts ready.

In every cycle a round-robin arbiter picks one queue whose head may legally issue. A head may issue only if its bank has finished its cycle time, the shared bus is free, and any rank-switch or read-to-write gap has elapsed. The winning head is driven out as a one-cycle command. A fixed number of cycles later, the block returns a response carrying the command's tag and write flag. This response is a read data return or a write acknowledgement.

Top module: `dsch_top`

## Requirements
- R1: The queue index is {addr[12], addr[11], addr[10:8]}: DIMM, then rank, then bank. Address bits [7:0] (line offset and controller select) and bits 13 and up do not affect which queue a request joins.
- R2: Each queue issues its requests in arrival order and holds at most 12 of them.
- R3: req_ready is low exactly when the queue selected by req_addr holds 12 requests. A request is accepted on a clock edge where req_valid and req_ready are both high.
- R4: Two commands to the same queue are at least 11 cycles apart, measured from the cycle of one command to the cycle of the next.
- R5: Any two consecutive commands are at least 2 cycles apart. A write following a write, and a read following a write, need only this spacing.
- R6: A read following a read with a different rank identity {addr[12], addr[11]} needs 1 extra cycle, for a spacing of 3.
- R7: A write following a read needs 2 extra cycles, for a spacing of 4.
- R8: The queues eligible to issue are searched upward, with wrap-around, starting from the index just after the last granted queue. The first eligible queue found is granted.
- R9: A response appears exactly 12 cycles after its command, carrying the command's tag and write flag. Responses come out in command order.
- R10: While reset is held, cmd_valid and resp_valid are low, all queues are empty and req_ready is high.
- R11: The scheduler never idles while a head is eligible. A request accepted by an idle block leaves as a command in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Target queue can take the request |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tag | input | 8 | Requester tag |
| cmd_valid | output | 1 | Command issued on the address bus this cycle |
| cmd_addr | output | 32 | Address of the issued command |
| cmd_write | output | 1 | Issued command is a write |
| cmd_tag | output | 8 | Tag of the issued command |
| resp_valid | output | 1 | Read data return or write acknowledgement |
| resp_write | output | 1 | Response belongs to a write |
| resp_tag | output | 8 | Tag of the completed request |

## Verification
Pairs of requests that reach an idle scheduler back to back are timed exactly. The pairs are chosen to separate each rule:
- two reads to one bank reached through different low address bits, which isolates bank cycle time and shows the ignored bits;
- reads to two banks in one rank, which isolates bus occupancy;
- reads to different ranks and to different DIMMs, which isolates the rank gap;
- read-then-write against write-then-read and write-then-write, which shows that the turnaround gap is one-sided.

Several writes queued behind a read all become eligible in the same cycle. They check that grant order follows the rotating pointer rather than arrival order, including the wrap from the top queue index to the bottom. A burst aimed at one queue drives it to full, so back-pressure and in-order draining are compared against a queue-occupancy model on every cycle.

// File: rtl/dsch_pkg.sv
package dsch_pkg;

    localparam int ADDR_W   = 32;
    localparam int TAG_W    = 8;
    localparam int BANK_LSB = 8;
    localparam int BANK_W   = 3;
    localparam int RANK_BIT = 11;
    localparam int DIMM_BIT = 12;
    localparam int RANK_ID_W = 2;
    localparam int QIDX_W   = BANK_W + RANK_ID_W;
    localparam int NQ       = 1 << QIDX_W;

    typedef logic [QIDX_W-1:0]    qidx_t;
    typedef logic [RANK_ID_W-1:0] rank_id_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [TAG_W-1:0]  tag;
    } dsch_req_t;

    typedef struct packed {
        logic             valid;
        logic             wr;
        logic [TAG_W-1:0] tag;
    } dsch_resp_t;

    function automatic qidx_t queue_of(input logic [ADDR_W-1:0] a);
        return {a[DIMM_BIT], a[RANK_BIT], a[BANK_LSB +: BANK_W]};
    endfunction

    function automatic rank_id_t rank_of(input logic [ADDR_W-1:0] a);
        return {a[DIMM_BIT], a[RANK_BIT]};
    endfunction

endpackage

// File: rtl/dsch_bank_fifo.sv
module dsch_bank_fifo
    import dsch_pkg::*;
#(
    parameter int DEPTH = 12
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push_i,
    input  dsch_req_t din_i,
    input  logic      pop_i,
    output dsch_req_t dout_o,
    output logic      empty_o,
    output logic      full_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    dsch_req_t       mem [DEPTH];
    logic [PW-1:0]   wr_ptr;
    logic [PW-1:0]   rd_ptr;
    logic [CW-1:0]   count;

    assign empty_o = (count == '0);
    assign full_o  = (count == CW'(DEPTH));
    assign dout_o  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_i) begin
            mem[wr_ptr] <= din_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_i) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_i) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_i, pop_i})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: a full queue is never written, an empty one never read
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        push_i |-> !full_o);
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> !empty_o);

endmodule

// File: rtl/dsch_rr_arb.sv
module dsch_rr_arb #(
    parameter int N = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req_i,
    output logic                 gnt_valid_o,
    output logic [$clog2(N)-1:0] gnt_idx_o
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] ptr;
    logic [IW-1:0] idx;

    always_comb begin
        gnt_valid_o = 1'b0;
        gnt_idx_o   = '0;
        idx         = '0;
        for (int k = 0; k < N; k++) begin
            idx = ptr + IW'(k);
            if (!gnt_valid_o && req_i[idx]) begin
                gnt_valid_o = 1'b1;
                gnt_idx_o   = idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (gnt_valid_o) begin
            ptr <= gnt_idx_o + 1'b1;
        end
    end

    // R8: a grant only goes to a requester, and a requester is never left idle
    assert_grant_requested_R8: assert property (@(posedge clk) disable iff (rst)
        gnt_valid_o |-> req_i[gnt_idx_o]);
    assert_work_conserving_R11: assert property (@(posedge clk) disable iff (rst)
        (|req_i) |-> gnt_valid_o);

endmodule

// File: rtl/dsch_resp_pipe.sv
module dsch_resp_pipe
    import dsch_pkg::*;
#(
    parameter int LAT = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  dsch_resp_t in_i,
    output dsch_resp_t out_o
);
    dsch_resp_t st [LAT];

    for (genvar s = 0; s < LAT; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) st[0] <= '0;
                else     st[0] <= in_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) st[s] <= '0;
                else     st[s] <= st[s-1];
            end
            // R9: an item moves one stage per cycle and is never dropped
            assert_stage_advance_R9: assert property (@(posedge clk) disable iff (rst)
                st[s-1].valid |=> (st[s].valid && st[s].tag == $past(st[s-1].tag)));
        end
    end

    assign out_o = st[LAT-1];

endmodule

// File: rtl/dsch_top.sv
module dsch_top
    import dsch_pkg::*;
#(
    parameter int QDEPTH    = 12,
    parameter int BANK_BUSY = 11,
    parameter int BUS_BUSY  = 2,
    parameter int RANK_GAP  = 1,
    parameter int RW_GAP    = 2,
    parameter int RESP_LAT  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_write,
    output logic [TAG_W-1:0]  cmd_tag,
    output logic              resp_valid,
    output logic              resp_write,
    output logic [TAG_W-1:0]  resp_tag
);
    localparam int GAP_MAX = BUS_BUSY + RANK_GAP + RW_GAP;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);
    localparam int BUSY_W  = (BANK_BUSY > 1) ? $clog2(BANK_BUSY) : 1;

    qidx_t             qsel;
    dsch_req_t         in_req;
    dsch_req_t         head [NQ];
    logic [NQ-1:0]     q_empty;
    logic [NQ-1:0]     q_full;
    logic [NQ-1:0]     q_push;
    logic [NQ-1:0]     q_pop;
    logic [NQ-1:0]     eligible;
    logic [BUSY_W-1:0] busy_cnt [NQ];
    logic [GAP_W-1:0]  need [NQ];

    logic              gnt_valid;
    qidx_t             gnt_idx;
    dsch_req_t         gnt_req;

    logic [GAP_W-1:0]  gap_cnt;
    logic              last_wr;
    rank_id_t          last_rank;

    dsch_resp_t        pipe_in;
    dsch_resp_t        pipe_out;

    // ---- request intake and decode ----
    assign qsel      = queue_of(req_addr);
    assign req_ready = !q_full[qsel];
    assign in_req    = '{addr: req_addr, wr: req_write, tag: req_tag};

    // ---- per-bank queue, cycle-time timer and spacing demand ----
    for (genvar i = 0; i < NQ; i++) begin : g_bank
        assign q_push[i] = req_valid && req_ready && (qsel == qidx_t'(i));
        assign q_pop[i]  = gnt_valid && (gnt_idx == qidx_t'(i));

        dsch_bank_fifo #(.DEPTH(QDEPTH)) u_fifo (
            .clk     (clk),
            .rst     (rst),
            .push_i  (q_push[i]),
            .din_i   (in_req),
            .pop_i   (q_pop[i]),
            .dout_o  (head[i]),
            .empty_o (q_empty[i]),
            .full_o  (q_full[i])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                busy_cnt[i] <= '0;
            end else if (q_pop[i]) begin
                busy_cnt[i] <= BUSY_W'(BANK_BUSY - 1);
            end else if (busy_cnt[i] != '0) begin
                busy_cnt[i] <= busy_cnt[i] - 1'b1;
            end
        end

        always_comb begin
            need[i] = GAP_W'(BUS_BUSY);
            if (!last_wr && !head[i].wr && (rank_of(head[i].addr) != last_rank)) begin
                need[i] = need[i] + GAP_W'(RANK_GAP);
            end
            if (!last_wr && head[i].wr) begin
                need[i] = need[i] + GAP_W'(RW_GAP);
            end
        end

        assign eligible[i] = !q_empty[i] && (busy_cnt[i] == '0) && (gap_cnt >= need[i]);
    end

    // ---- address bus arbitration ----
    dsch_rr_arb #(.N(NQ)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .req_i       (eligible),
        .gnt_valid_o (gnt_valid),
        .gnt_idx_o   (gnt_idx)
    );

    assign gnt_req = head[gnt_idx];

    // ---- shared bus history ----
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt   <= GAP_W'(GAP_MAX);
            last_wr   <= 1'b1;
            last_rank <= '0;
        end else if (gnt_valid) begin
            gap_cnt   <= GAP_W'(1);
            last_wr   <= gnt_req.wr;
            last_rank <= rank_of(gnt_req.addr);
        end else if (gap_cnt != GAP_W'(GAP_MAX)) begin
            gap_cnt   <= gap_cnt + 1'b1;
        end
    end

    // ---- command register ----
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            cmd_addr  <= '0;
            cmd_write <= 1'b0;
            cmd_tag   <= '0;
        end else begin
            cmd_valid <= gnt_valid;
            cmd_addr  <= gnt_valid ? gnt_req.addr : cmd_addr;
            cmd_write <= gnt_valid ? gnt_req.wr   : cmd_write;
            cmd_tag   <= gnt_valid ? gnt_req.tag  : cmd_tag;
        end
    end

    // ---- fixed-latency response return ----
    assign pipe_in = '{valid: cmd_valid, wr: cmd_write, tag: cmd_tag};

    dsch_resp_pipe #(.LAT(RESP_LAT)) u_resp (
        .clk   (clk),
        .rst   (rst),
        .in_i  (pipe_in),
        .out_o (pipe_out)
    );

    assign resp_valid = pipe_out.valid;
    assign resp_write = pipe_out.wr;
    assign resp_tag   = pipe_out.tag;

    // R4: the arbiter never picks a bank whose cycle-time timer is running
    assert_bank_busy_R4: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> (busy_cnt[gnt_idx] == '0));

    // R5: two commands never occupy adjacent cycles
    if (BUS_BUSY >= 2) begin : g_bus_chk
        assert_bus_gap_R5: assert property (@(posedge clk) disable iff (rst)
            cmd_valid |=> !cmd_valid);
    end

    // R7: a write granted right after a read has waited for the turnaround
    assert_turnaround_R7: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && gnt_req.wr && !last_wr) |-> (gap_cnt >= GAP_W'(BUS_BUSY + RW_GAP)));

    // R3: a request offered to a full queue is held off
    assert_backpressure_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && q_full[queue_of(req_addr)]) |-> !req_ready);

endmodule

// File: tb/tb_dsch_top.sv
module tb_dsch_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_tag = '0;
    logic        cmd_valid;
    logic [31:0] cmd_addr;
    logic        cmd_write;
    logic [7:0]  cmd_tag;
    logic        resp_valid;
    logic        resp_write;
    logic [7:0]  resp_tag;

    always #4 clk = ~clk;   // 125 MHz

    dsch_top dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_tag(req_tag),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_tag(cmd_tag),
        .resp_valid(resp_valid), .resp_write(resp_write), .resp_tag(resp_tag)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    int          cmd_cyc [256];
    int          occ [32];
    int          bank_last [32];
    logic [40:0] expq [32][$];
    int          due_q [$];
    logic [8:0]  rsp_q [$];
    bit          have_prev = 1'b0;
    int          prev_cyc;
    logic        prev_wr;
    logic [1:0]  prev_rank;
    int          ready_low_seen = 0;

    function automatic int qof(input logic [31:0] a);
        return int'({a[12], a[11], a[10:8]});
    endfunction

    function automatic logic [1:0] rof(input logic [31:0] a);
        return {a[12], a[11]};
    endfunction

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // ---- driver ----
    task automatic send(input logic [31:0] a, input logic w, input logic [7:0] t);
        req_valid = 1'b1;
        req_addr  = a;
        req_write = w;
        req_tag   = t;
        do @(negedge clk); while (!req_ready);
        expq[qof(a)].push_back({a, w, t});
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (40) @(posedge clk);
        #1;
    endtask

    task automatic chk_delta(input int ta, input int tb, input int exp, input string rq);
        chk(cmd_cyc[tb] - cmd_cyc[ta] == exp, rq, cmd_cyc[tb] - cmd_cyc[ta], exp);
    endtask

    // ---- monitor / scoreboard ----
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (cmd_valid) begin
                int b;
                int need;
                b = qof(cmd_addr);
                occ[b]--;
                if (expq[b].size() == 0) begin
                    chk(1'b0, "R1 R2 unexpected command", longint'(cmd_tag), -1);
                end else begin
                    logic [40:0] e;
                    e = expq[b].pop_front();
                    chk({cmd_addr, cmd_write, cmd_tag} == e, "R1 R2 command content/order",
                        longint'({cmd_addr, cmd_write, cmd_tag}), longint'(e));
                end
                if (bank_last[b] >= 0)
                    chk(cyc - bank_last[b] >= 11, "R4 bank cycle time", cyc - bank_last[b], 11);
                bank_last[b] = cyc;
                if (have_prev) begin
                    need = 2;
                    if (!prev_wr && !cmd_write && rof(cmd_addr) != prev_rank) need += 1;
                    if (!prev_wr && cmd_write) need += 2;
                    chk(cyc - prev_cyc >= need, "R5 R6 R7 bus spacing", cyc - prev_cyc, need);
                end
                have_prev = 1'b1;
                prev_cyc  = cyc;
                prev_wr   = cmd_write;
                prev_rank = rof(cmd_addr);
                cmd_cyc[cmd_tag] = cyc;
                due_q.push_back(cyc + 12);
                rsp_q.push_back({cmd_write, cmd_tag});
            end
            begin
                bit exp_rsp;
                exp_rsp = (due_q.size() > 0) && (due_q[0] == cyc);
                if (exp_rsp || resp_valid) begin
                    chk(resp_valid == exp_rsp, "R9 response timing", resp_valid, exp_rsp);
                    if (exp_rsp && resp_valid) begin
                        logic [8:0] r;
                        void'(due_q.pop_front());
                        r = rsp_q.pop_front();
                        chk({resp_write, resp_tag} == r, "R9 response tag/type",
                            {resp_write, resp_tag}, r);
                    end else if (exp_rsp) begin
                        void'(due_q.pop_front());
                        void'(rsp_q.pop_front());
                    end
                end
            end
            if (req_valid) begin
                chk(req_ready == (occ[qof(req_addr)] < 12), "R3 ready vs queue occupancy",
                    req_ready, occ[qof(req_addr)] < 12);
                if (!req_ready) ready_low_seen++;
                if (req_ready) occ[qof(req_addr)]++;
            end
        end
    end

    // ---- watchdog ----
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // ---- stimulus ----
    initial begin
        for (int i = 0; i < 256; i++) cmd_cyc[i] = -1;
        for (int i = 0; i < 32; i++) begin
            occ[i] = 0;
            bank_last[i] = -1;
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(cmd_valid == 1'b0, "R10 cmd_valid in reset", cmd_valid, 0);
        chk(resp_valid == 1'b0, "R10 resp_valid in reset", resp_valid, 0);
        chk(req_ready == 1'b1, "R10 req_ready in reset", req_ready, 1);
        @(posedge clk);
        #1;
        rst = 1'b0;

        // R11: idle block issues in the cycle after acceptance (queue 16 via bit 12)
        fork
            send(32'h0000_1000, 1'b0, 8'd1);
            begin @(negedge clk); end
        join
        drain();
        chk(cmd_cyc[1] >= 0, "R11 command issued", cmd_cyc[1], 1);

        // R1 R4: low bits differ, same queue 0 -> bank cycle time spacing
        send(32'h0000_0000, 1'b0, 8'd2);
        send(32'h0000_00FF, 1'b0, 8'd3);
        drain();
        chk_delta(2, 3, 11, "R1 R4 same bank via ignored low bits");

        // R5: two reads, same rank, different banks
        send(32'h0000_0100, 1'b0, 8'd4);
        send(32'h0000_0200, 1'b0, 8'd5);
        drain();
        chk_delta(4, 5, 2, "R5 bus occupancy");

        // R6: read then read to another rank
        send(32'h0000_0300, 1'b0, 8'd6);
        send(32'h0000_0800, 1'b0, 8'd7);
        drain();
        chk_delta(6, 7, 3, "R6 rank switch read-read");

        // R6: read then read to another DIMM
        send(32'h0000_0000, 1'b0, 8'd8);
        send(32'h0000_1100, 1'b0, 8'd9);
        drain();
        chk_delta(8, 9, 3, "R6 DIMM switch read-read");

        // R7: read then write
        send(32'h0000_0400, 1'b0, 8'd10);
        send(32'h0000_0500, 1'b1, 8'd11);
        drain();
        chk_delta(10, 11, 4, "R7 read-to-write turnaround");

        // R5 R7: write then read needs no extra gap
        send(32'h0000_0600, 1'b1, 8'd12);
        send(32'h0000_0700, 1'b0, 8'd13);
        drain();
        chk_delta(12, 13, 2, "R5 R7 write-to-read");

        // R5 R6: write then write to another rank needs no extra gap
        send(32'h0000_0100, 1'b1, 8'd14);
        send(32'h0000_0900, 1'b1, 8'd15);
        drain();
        chk_delta(14, 15, 2, "R5 R6 write-write across ranks");

        // R8: writes queued behind a read, arriving in order 6,3,1
        send(32'h0000_0000, 1'b0, 8'd20);
        send(32'h0000_0600, 1'b1, 8'd21);
        send(32'h0000_0300, 1'b1, 8'd22);
        send(32'h0000_0100, 1'b1, 8'd23);
        drain();
        chk_delta(20, 23, 4, "R8 queue 1 first after queue 0");
        chk_delta(23, 22, 2, "R8 queue 3 second");
        chk_delta(22, 21, 2, "R8 queue 6 last");

        // R8: wrap from the top index to the bottom
        send(32'h0000_1E00, 1'b0, 8'd30);
        send(32'h0000_0200, 1'b1, 8'd31);
        send(32'h0000_1F00, 1'b1, 8'd32);
        drain();
        chk_delta(30, 32, 4, "R8 queue 31 after queue 30");
        chk_delta(32, 31, 2, "R8 wrap to queue 2");

        // R2 R3: burst into queue 5 fills it and back-pressures
        for (int k = 0; k < 16; k++) begin
            send(32'h0000_0500 + 32'(k * 4), k[0], 8'(100 + k));
        end
        repeat (200) @(posedge clk);
        #1;
        chk(ready_low_seen > 0, "R3 ready deasserted on full queue", ready_low_seen, 1);
        chk(cmd_cyc[115] - cmd_cyc[100] == 15 * 11, "R2 R4 burst drained in order",
            cmd_cyc[115] - cmd_cyc[100], 15 * 11);
        chk(due_q.size() == 0, "R9 all responses returned", due_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule